// File: doc/BRIEF.md
# Logic Analyzer Command Decoder

This block sits behind a host serial receiver and turns its byte stream into analyzer configuration. Each command opens with one opcode byte. Opcodes with the top bit clear are one-byte commands. Opcodes with the top bit set are followed by four argument bytes, which are gathered into a 32-bit word. Completed commands load configuration registers: the flag word, the sample-rate divider, the capture count, and a bank of four trigger registers for every trigger stage. They also produce single-cycle control pulses for run, reset and metadata request.

When asked to identify itself, the block sends a fixed four-byte signature on a byte-wide transmit stream. The byte timing of the serial link, the metadata contents, and the sampling and trigger engines lie outside this block. Those parts consume the registers and pulses it drives.

Both byte streams use valid/ready handshakes.
- On receive, a byte is taken on a clock edge where `rx_valid` and `rx_ready` are both high.
- `rx_ready` drops for the whole time an identify reply is pending or being sent. The sender must hold its byte until `rx_ready` returns.
- On transmit, a byte leaves on an edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_data` and `tx_valid` hold.

Top module: `la_cmd_decoder`

## Requirements
- R1: An opcode byte with bit 7 set starts a five-byte command: the opcode and four argument bytes. Any other opcode is a complete one-byte command. No pulse or write strobe fires while a five-byte command is still incomplete.
- R2: Argument bytes arrive least significant first. A command with opcode 0x81 loads the whole 32-bit word into `capture_cnt_o`.
- R3: A register write becomes visible on the clock edge after the edge that accepts the fifth byte. On that same edge `wr_stb_o` goes high for exactly one cycle and `wr_addr_o` carries the opcode.
- R4: Opcode 0x82 loads `flags_o` from argument bits 15:0. Argument bits 31:16 have no effect.
- R5: Opcode 0x80 loads the 24-bit `divider_o` from argument bits 23:0. Argument bits 31:24 have no effect.
- R6: Opcode 0xC0 + 4·n + k writes trigger stage n for n below NUM_STAGES, where k selects the register: 0 mask, 1 value, 2 config, 3 edge. Stage n sits at bits 32n+31..32n of the matching flat output. An opcode of this form with n ≥ NUM_STAGES writes nothing and gives no strobe.
- R7: Opcode 0x00 pulses `reset_o` for one cycle, with the same timing as R3. Registers keep their contents. Five consecutive 0x00 bytes leave the parser at a command boundary from any point inside a partly received command. The byte after them is then decoded as an opcode.
- R8: Opcode 0x01 pulses `run_o` and opcode 0x04 pulses `meta_req_o`. Each pulse lasts one cycle, with the same timing as R3.
- R9: Opcode 0x02 raises `tx_valid` on the same edge as R3. The reply bytes are 0x31, 0x53, 0x4C, 0x4F in that order, one per handshake. Data holds while the sink stalls.
- R10: `rx_ready` is low from the edge after an identify opcode is accepted until the last reply byte is taken. It is high otherwise.
- R11: One-byte opcodes other than 0x00, 0x01, 0x02 and 0x04 do nothing. Five-byte commands with an unmapped opcode take their four argument bytes but write nothing and give no strobe.
- R12: After reset, every register output and pulse is zero, `tx_valid` is low and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive byte accepted when high |
| rx_data | input | 8 | Receive byte |
| tx_valid | output | 1 | Reply byte valid |
| tx_ready | input | 1 | Reply sink ready |
| tx_data | output | 8 | Reply byte |
| flags_o | output | 16 | Flag register |
| divider_o | output | 24 | Sample-rate divider |
| capture_cnt_o | output | 32 | Capture count |
| trig_mask_o | output | 32·NUM_STAGES | Trigger mask, one word per stage |
| trig_value_o | output | 32·NUM_STAGES | Trigger value, one word per stage |
| trig_cfg_o | output | 32·NUM_STAGES | Trigger config, one word per stage |
| trig_edge_o | output | 32·NUM_STAGES | Trigger edge select, one word per stage |
| run_o | output | 1 | Start-capture pulse |
| reset_o | output | 1 | Reset pulse |
| meta_req_o | output | 1 | Metadata request pulse |
| wr_stb_o | output | 1 | Register write strobe |
| wr_addr_o | output | 8 | Opcode of the last register write |

## Verification
The bench builds the block with its default of four trigger stages. With that setting, opcodes 0xC0 to 0xCF cover every stage and register kind. Opcodes 0xD0 and above fall in the out-of-range form, so the stage-limit decode and its silent drop are both exercised. A fixed-seed random mix of mapped, unmapped and one-byte commands runs alongside directed runs of zero bytes from each partial-command depth, plus identify replies under random sink stalls.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;
  localparam int BYTE_W    = 8;
  localparam int ARG_BYTES = 4;
  localparam int ARG_W     = ARG_BYTES * BYTE_W;
  localparam int FLAG_W    = 16;
  localparam int DIV_W     = 24;
  localparam int SIG_LEN   = 4;
  localparam int TRIG_KINDS  = 4;
  localparam int TRIG_STRIDE = 4;
  localparam int STAGE_FIELD = 4;

  localparam logic [BYTE_W-1:0] OP_RESET     = 8'h00;
  localparam logic [BYTE_W-1:0] OP_RUN       = 8'h01;
  localparam logic [BYTE_W-1:0] OP_IDENT     = 8'h02;
  localparam logic [BYTE_W-1:0] OP_META      = 8'h04;
  localparam logic [BYTE_W-1:0] OP_DIV       = 8'h80;
  localparam logic [BYTE_W-1:0] OP_CNT       = 8'h81;
  localparam logic [BYTE_W-1:0] OP_FLAGS     = 8'h82;
  localparam logic [BYTE_W-1:0] OP_TRIG_BASE = 8'hC0;

  typedef enum logic [1:0] {TK_MASK, TK_VALUE, TK_CFG, TK_EDGE} trig_kind_e;

  typedef struct packed {
    logic [BYTE_W-1:0] op;
    logic [ARG_W-1:0]  arg;
  } cmd_t;

  // byte 0 leaves first
  localparam logic [SIG_LEN*BYTE_W-1:0] SIGNATURE = {8'h4F, 8'h4C, 8'h53, 8'h31};
endpackage

// File: rtl/la_cmd_framer.sv
module la_cmd_framer
  import la_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_take,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              cmd_vld,
  output cmd_t              cmd
);
  localparam int CNT_W = $clog2(ARG_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_ARG = CNT_W'(ARG_BYTES);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] op_q;
  logic [ARG_W-1:0]  arg_q;
  logic              vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      op_q  <= '0;
      arg_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (byte_take) begin
        if (cnt_q == '0) begin
          op_q <= byte_data;
          if (byte_data[BYTE_W-1]) cnt_q <= CNT_W'(1);
          else                     vld_q <= 1'b1;
        end else begin
          // least significant byte first: shift down from the top
          arg_q <= {byte_data, arg_q[ARG_W-1:BYTE_W]};
          if (cnt_q == LAST_ARG) begin
            cnt_q <= '0;
            vld_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      end
    end
  end

  assign cmd_vld = vld_q;
  assign cmd.op  = op_q;
  assign cmd.arg = arg_q;
endmodule

// File: rtl/la_cmd_regfile.sv
module la_cmd_regfile
  import la_cmd_pkg::*;
#(
  parameter int NUM_STAGES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_vld,
  input  cmd_t                        cmd,
  output logic [FLAG_W-1:0]           flags_o,
  output logic [DIV_W-1:0]            divider_o,
  output logic [ARG_W-1:0]            capture_cnt_o,
  output logic [NUM_STAGES*ARG_W-1:0] trig_mask_o,
  output logic [NUM_STAGES*ARG_W-1:0] trig_value_o,
  output logic [NUM_STAGES*ARG_W-1:0] trig_cfg_o,
  output logic [NUM_STAGES*ARG_W-1:0] trig_edge_o,
  output logic                        run_o,
  output logic                        reset_o,
  output logic                        meta_req_o,
  output logic                        wr_stb_o,
  output logic [BYTE_W-1:0]           wr_addr_o
);
  logic trig_hit;
  logic known_long;

  assign trig_hit   = (cmd.op[7:6] == OP_TRIG_BASE[7:6]) &&
                      (int'(cmd.op[2 +: STAGE_FIELD]) < NUM_STAGES);
  assign known_long = (cmd.op == OP_FLAGS) || (cmd.op == OP_DIV) ||
                      (cmd.op == OP_CNT) || trig_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_o       <= '0;
      divider_o     <= '0;
      capture_cnt_o <= '0;
      run_o         <= 1'b0;
      reset_o       <= 1'b0;
      meta_req_o    <= 1'b0;
      wr_stb_o      <= 1'b0;
      wr_addr_o     <= '0;
    end else begin
      run_o      <= cmd_vld && (cmd.op == OP_RUN);
      reset_o    <= cmd_vld && (cmd.op == OP_RESET);
      meta_req_o <= cmd_vld && (cmd.op == OP_META);
      wr_stb_o   <= cmd_vld && known_long;
      if (cmd_vld && known_long) wr_addr_o <= cmd.op;
      if (cmd_vld) begin
        unique case (cmd.op)
          OP_FLAGS: flags_o       <= cmd.arg[FLAG_W-1:0];
          OP_DIV:   divider_o     <= cmd.arg[DIV_W-1:0];
          OP_CNT:   capture_cnt_o <= cmd.arg;
          default: ;
        endcase
      end
    end
  end

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    logic [ARG_W-1:0] bank_q [TRIG_KINDS];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int k = 0; k < TRIG_KINDS; k++) bank_q[k] <= '0;
      end else if (cmd_vld) begin
        for (int k = 0; k < TRIG_KINDS; k++) begin
          if (cmd.op == OP_TRIG_BASE + BYTE_W'(TRIG_STRIDE * s + k))
            bank_q[k] <= cmd.arg;
        end
      end
    end

    assign trig_mask_o [s*ARG_W +: ARG_W] = bank_q[TK_MASK];
    assign trig_value_o[s*ARG_W +: ARG_W] = bank_q[TK_VALUE];
    assign trig_cfg_o  [s*ARG_W +: ARG_W] = bank_q[TK_CFG];
    assign trig_edge_o [s*ARG_W +: ARG_W] = bank_q[TK_EDGE];
  end
endmodule

// File: rtl/la_cmd_id_tx.sv
module la_cmd_id_tx
  import la_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data
);
  localparam int IDX_W = $clog2(SIG_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SIG_LEN - 1);

  logic [IDX_W-1:0] idx_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (start && !busy_q) begin
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && tx_ready) begin
      if (idx_q == LAST_IDX) busy_q <= 1'b0;
      else                   idx_q  <= idx_q + IDX_W'(1);
    end
  end

  assign tx_valid = busy_q;
  assign tx_data  = SIGNATURE[idx_q*BYTE_W +: BYTE_W];
endmodule

// File: rtl/la_cmd_decoder.sv
module la_cmd_decoder
  import la_cmd_pkg::*;
#(
  parameter int NUM_STAGES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rx_valid,
  output logic                        rx_ready,
  input  logic [7:0]                  rx_data,
  output logic                        tx_valid,
  input  logic                        tx_ready,
  output logic [7:0]                  tx_data,
  output logic [15:0]                 flags_o,
  output logic [23:0]                 divider_o,
  output logic [31:0]                 capture_cnt_o,
  output logic [NUM_STAGES*32-1:0]    trig_mask_o,
  output logic [NUM_STAGES*32-1:0]    trig_value_o,
  output logic [NUM_STAGES*32-1:0]    trig_cfg_o,
  output logic [NUM_STAGES*32-1:0]    trig_edge_o,
  output logic                        run_o,
  output logic                        reset_o,
  output logic                        meta_req_o,
  output logic                        wr_stb_o,
  output logic [7:0]                  wr_addr_o
);
  logic cmd_vld;
  cmd_t cmd;
  logic id_pending;

  assign id_pending = cmd_vld && (cmd.op == OP_IDENT);
  assign rx_ready   = !tx_valid && !id_pending;

  la_cmd_framer u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_take (rx_valid && rx_ready),
    .byte_data (rx_data),
    .cmd_vld   (cmd_vld),
    .cmd       (cmd)
  );

  la_cmd_regfile #(.NUM_STAGES(NUM_STAGES)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_vld       (cmd_vld),
    .cmd           (cmd),
    .flags_o       (flags_o),
    .divider_o     (divider_o),
    .capture_cnt_o (capture_cnt_o),
    .trig_mask_o   (trig_mask_o),
    .trig_value_o  (trig_value_o),
    .trig_cfg_o    (trig_cfg_o),
    .trig_edge_o   (trig_edge_o),
    .run_o         (run_o),
    .reset_o       (reset_o),
    .meta_req_o    (meta_req_o),
    .wr_stb_o      (wr_stb_o),
    .wr_addr_o     (wr_addr_o)
  );

  la_cmd_id_tx u_id (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (id_pending),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data)
  );
endmodule

// File: rtl/la_cmd_decoder_chk.sv
module la_cmd_decoder_chk #(
  parameter int NUM_STAGES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_ready,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic [15:0] flags_o,
  input logic [23:0] divider_o,
  input logic [31:0] capture_cnt_o,
  input logic        run_o,
  input logic        reset_o,
  input logic        meta_req_o,
  input logic        wr_stb_o,
  input logic [7:0]  wr_addr_o
);
  assert_one_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({run_o, reset_o, meta_req_o, wr_stb_o}));

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);

  assert_cnt_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(capture_cnt_o) |-> (wr_stb_o && wr_addr_o == 8'h81));

  assert_flag_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flags_o) |-> (wr_stb_o && wr_addr_o == 8'h82));

  assert_div_needs_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(divider_o) |-> (wr_stb_o && wr_addr_o == 8'h80));

  assert_reset_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_o |=> !reset_o);

  assert_run_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |=> !run_o);

  assert_meta_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    meta_req_o |=> !meta_req_o);

  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_rx_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);
endmodule

bind la_cmd_decoder la_cmd_decoder_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_ready      (rx_ready),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .tx_data       (tx_data),
  .flags_o       (flags_o),
  .divider_o     (divider_o),
  .capture_cnt_o (capture_cnt_o),
  .run_o         (run_o),
  .reset_o       (reset_o),
  .meta_req_o    (meta_req_o),
  .wr_stb_o      (wr_stb_o),
  .wr_addr_o     (wr_addr_o)
);

// File: tb/la_cmd_decoder_tb.sv
`timescale 1ns/1ps
module la_cmd_decoder_tb;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic rx_ready;
  logic [7:0] rx_data = '0;
  logic tx_valid;
  logic tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic [15:0] flags_o;
  logic [23:0] divider_o;
  logic [31:0] capture_cnt_o;
  logic [NS*32-1:0] trig_mask_o, trig_value_o, trig_cfg_o, trig_edge_o;
  logic run_o, reset_o, meta_req_o, wr_stb_o;
  logic [7:0] wr_addr_o;

  always #2 clk = ~clk;

  la_cmd_decoder #(.NUM_STAGES(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .flags_o(flags_o), .divider_o(divider_o), .capture_cnt_o(capture_cnt_o),
    .trig_mask_o(trig_mask_o), .trig_value_o(trig_value_o),
    .trig_cfg_o(trig_cfg_o), .trig_edge_o(trig_edge_o),
    .run_o(run_o), .reset_o(reset_o), .meta_req_o(meta_req_o),
    .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  int          m_cnt = 0;
  logic [7:0]  m_op;
  logic [31:0] m_arg;
  logic [15:0] e_flags = '0;
  logic [23:0] e_div = '0;
  logic [31:0] e_cnt = '0;
  logic [31:0] e_trig [4][NS];
  bit ev_stb, ev_run, ev_rst, ev_meta, ev_id;
  logic [7:0] ev_addr;
  string ev_tag;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sig_byte(input int i);
    logic [31:0] s;
    s = "1SLO";
    return s[31-8*i -: 8];
  endfunction

  function automatic logic [NS*32-1:0] flat(input int kind);
    logic [NS*32-1:0] v;
    for (int s = 0; s < NS; s++) v[s*32 +: 32] = e_trig[kind][s];
    return v;
  endfunction

  task automatic exec_long(input logic [7:0] op, input logic [31:0] arg);
    bit known;
    known = 1'b0;
    if (op == 8'h82) begin e_flags = arg[15:0]; known = 1; ev_tag = "R4"; end
    else if (op == 8'h80) begin e_div = arg[23:0]; known = 1; ev_tag = "R5"; end
    else if (op == 8'h81) begin e_cnt = arg; known = 1; ev_tag = "R2"; end
    else if (op[7:6] == 2'b11 && int'(op[5:2]) < NS) begin
      e_trig[op[1:0]][op[5:2]] = arg; known = 1; ev_tag = "R6";
    end else ev_tag = "R11";
    ev_stb = known;
    ev_addr = op;
  endtask

  task automatic model_byte(input logic [7:0] b);
    ev_stb = 0; ev_run = 0; ev_rst = 0; ev_meta = 0; ev_id = 0; ev_tag = "R1";
    if (m_cnt == 0) begin
      m_op = b;
      if (b[7]) m_cnt = 1;
      else begin
        case (b)
          8'h00: begin ev_rst = 1; ev_tag = "R7"; end
          8'h01: begin ev_run = 1; ev_tag = "R8"; end
          8'h02: begin ev_id = 1; ev_tag = "R9"; end
          8'h04: begin ev_meta = 1; ev_tag = "R8"; end
          default: ev_tag = "R11";
        endcase
      end
    end else begin
      m_arg[8*(m_cnt-1) +: 8] = b;
      if (m_cnt == 4) begin m_cnt = 0; exec_long(m_op, m_arg); end
      else m_cnt++;
    end
  endtask

  task automatic drain_id();
    for (int i = 0; i < 4; i++) begin
      int stall;
      stall = $urandom_range(0, 2);
      chk("R9 tx_valid", 128'(tx_valid), 128'(1));
      chk("R9 tx_data", 128'(tx_data), 128'(sig_byte(i)));
      chk("R10 rx_ready busy", 128'(rx_ready), 128'(0));
      repeat (stall) begin
        @(negedge clk);
        chk("R9 hold", 128'(tx_data), 128'(sig_byte(i)));
      end
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
    end
    chk("R9 reply end", 128'(tx_valid), 128'(0));
    chk("R10 rx_ready back", 128'(rx_ready), 128'(1));
  endtask

  task automatic check_regs();
    chk("R4 flags", 128'(flags_o), 128'(e_flags));
    chk("R5 divider", 128'(divider_o), 128'(e_div));
    chk("R2 capture count", 128'(capture_cnt_o), 128'(e_cnt));
    chk("R6 trig mask", 128'(trig_mask_o), 128'(flat(0)));
    chk("R6 trig value", 128'(trig_value_o), 128'(flat(1)));
    chk("R6 trig cfg", 128'(trig_cfg_o), 128'(flat(2)));
    chk("R6 trig edge", 128'(trig_edge_o), 128'(flat(3)));
  endtask

  task automatic send_byte(input logic [7:0] b);
    string t;
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1'b1;
    rx_data = b;
    model_byte(b);
    @(negedge clk);
    rx_valid = 1'b0;
    @(negedge clk);
    t = ev_tag;
    chk({t, " R3 strobe"}, 128'(wr_stb_o), 128'(ev_stb));
    if (ev_stb) chk({t, " R3 addr"}, 128'(wr_addr_o), 128'(ev_addr));
    chk({t, " R7 reset pulse"}, 128'(reset_o), 128'(ev_rst));
    chk({t, " R8 run pulse"}, 128'(run_o), 128'(ev_run));
    chk({t, " R8 meta pulse"}, 128'(meta_req_o), 128'(ev_meta));
    check_regs();
    if (ev_id) drain_id();
    else chk({t, " R9 no reply"}, 128'(tx_valid), 128'(0));
    // pulse and strobe last one cycle
    if (!ev_id) begin
      @(negedge clk);
      chk("R3 strobe width", 128'({wr_stb_o, run_o, reset_o, meta_req_o}), 128'(0));
    end
  endtask

  task automatic send_long(input logic [7:0] op, input logic [31:0] arg);
    send_byte(op);
    for (int i = 0; i < 4; i++) send_byte(arg[8*i +: 8]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] long_ops [4];
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < 4; k++) for (int s = 0; s < NS; s++) e_trig[k][s] = '0;
    long_ops[0] = 8'h80; long_ops[1] = 8'h81; long_ops[2] = 8'h82; long_ops[3] = 8'hC0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 regs", 128'({flags_o, divider_o, capture_cnt_o}), 128'(0));
    chk("R12 trig", 128'({trig_mask_o, trig_value_o}), 128'(0));
    chk("R12 trig2", 128'({trig_cfg_o, trig_edge_o}), 128'(0));
    chk("R12 pulses", 128'({run_o, reset_o, meta_req_o, wr_stb_o, tx_valid}), 128'(0));
    chk("R12 rx_ready", 128'(rx_ready), 128'(1));

    // directed corner cases
    send_long(8'h82, 32'hDEAD_BEEF);   // R4 upper half dropped
    send_long(8'h80, 32'hFF12_3456);   // R5 top byte dropped
    send_long(8'h81, 32'h8765_4321);   // R2 byte order
    send_long(8'hCF, 32'hA5A5_0F0F);   // R6 last stage, edge
    send_long(8'hC4, 32'h1111_2222);   // R6 stage 1 mask
    send_long(8'hD0, 32'hFFFF_FFFF);   // R6 stage out of range
    send_long(8'hFF, 32'h0BAD_CAFE);   // R11 unmapped long
    send_byte(8'h07);                  // R11 unknown short
    send_byte(8'h7F);                  // R11 unknown short
    send_byte(8'h01);                  // R8 run
    send_byte(8'h04);                  // R8 meta
    send_byte(8'h02);                  // R9 identify
    // R7 resync from every partial depth
    for (int depth = 0; depth < 5; depth++) begin
      send_byte(8'h81);
      for (int a = 1; a < depth; a++) send_byte(8'($urandom_range(1, 255)));
      repeat (5) send_byte(8'h00);
      send_byte(8'h01);
      chk("R7 resync idle", 128'(m_cnt), 128'(0));
    end

    // constrained random mix
    for (int n = 0; n < 300; n++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 4) begin
        logic [7:0] op;
        op = long_ops[$urandom_range(0, 3)];
        if (op == 8'hC0) op = 8'hC0 + 8'($urandom_range(0, 63));
        send_long(op, $urandom());
      end else if (sel < 6) begin
        send_long(8'h80 + 8'($urandom_range(0, 127)), $urandom());
      end else if (sel < 9) begin
        send_byte(8'($urandom_range(0, 127)));
      end else begin
        send_byte(8'h02);
      end
    end
    finish_run();
  end
endmodule